// File: doc/BRIEF.md
# Cascadable Segment Line Loader

The block gathers one display line of pixel bits (160 by default) from a narrow parallel data bus. The bus is clocked by the data shift clock `clk`. Several loaders share one bus and are joined in a daisy chain by an enable signal. Each loader captures bus data only while it owns the chain enable. After a latch pulse, a loader sits idle until its incoming enable is seen. It then fills its data latch one byte word at a time. When the last word of its line has been stored, it hands the enable to the next chip and ignores the bus until the next latch pulse.

The bus can be packed in two ways, chosen by `wide_mode`:
- **Byte mode:** one clock delivers a full byte.
- **Nibble mode:** two clocks deliver the two halves of a byte.

`fill_rev` sets which end of the latch is filled first. It also swaps the roles of the two chain pins. When the latch pulse `lp` falls, the whole data latch is copied in one step into the line register `line_q`, which feeds the output stage. `lp` is sampled on `clk`.

Top module: `seg_line_loader`

## Requirements
- R1: While `rst` is high and in the cycle after it drops, `line_q` is all zeros and both `chain_a_out` and `chain_b_out` are low.
- R2: In byte mode (`wide_mode`=1) one byte is stored per clock. With `fill_rev`=0, bit b of the w-th captured byte (w counted from 0) lands in `line_q` bit 8w+b after the next transfer.
- R3: In nibble mode (`wide_mode`=0) only `data_in[3:0]` is used. The first clock supplies bits 7..4 of the word and the second clock supplies bits 3..0. `data_in[7:4]` has no effect.
- R4: Capture starts at the first clock edge where the block is idle, `lp` is low and the selected incoming chain pin is high, and that edge's data is captured. Bus clocks before that edge change nothing.
- R5: Once the final word has been captured, the outgoing chain pin is high for exactly one clock. It rises at the edge after the capture edge.
- R6: After the full line is stored, further clocks and incoming enables store nothing and raise no second chain pulse until the next latch pulse.
- R7: While `lp` is high, no data is captured, the word position returns to the first word, and a half-assembled nibble is discarded. A line interrupted this way restarts from its first word.
- R8: At the first clock edge where `lp` is sampled low after being sampled high, the whole data latch is copied into `line_q`. `line_q` changes at no other edge.
- R9: With `fill_rev`=1, word w lands in pixels 8(19-w)+b (default size), `chain_b_in` is the incoming enable and `chain_a_out` is the outgoing one. With `fill_rev`=0, `chain_a_in` and `chain_b_out` take those roles. The unused output stays low, and the unused input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data shift clock |
| rst | input | 1 | Synchronous active-high reset |
| lp | input | 1 | Latch pulse; high resets control, falling edge transfers the line |
| wide_mode | input | 1 | 1 = byte per clock, 0 = nibble per clock |
| fill_rev | input | 1 | 1 = fill from the top pixel end, chain input on b side |
| data_in | input | 8 | Parallel display data bus |
| chain_a_in | input | 1 | Incoming enable when `fill_rev`=0 |
| chain_b_in | input | 1 | Incoming enable when `fill_rev`=1 |
| chain_a_out | output | 1 | Outgoing enable pulse when `fill_rev`=1 |
| chain_b_out | output | 1 | Outgoing enable pulse when `fill_rev`=0 |
| line_q | output | 160 | Line register feeding the drivers |

## Verification
The hardest state to reach from the ports is a latch pulse that lands in nibble mode after an odd number of nibbles, partway through a line. Here both the word position and the nibble phase must be discarded. The bench feeds seven words plus one extra nibble, pulses `lp`, and then loads a complete new nibble-mode line. Any leftover phase or position would rotate or shift every byte of the transferred line. Storage after completion is checked the same way: the enable is held high and the bus toggles for several clocks after the handoff, and the next transfer must still show the original line.

// File: rtl/seg_ldr_pkg.sv
package seg_ldr_pkg;

    localparam int unsigned BYTE_BITS = 8;
    localparam int unsigned HALF_BITS = BYTE_BITS / 2;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_FILL  = 2'd1,
        ST_HAND  = 2'd2,
        ST_SPENT = 2'd3
    } fill_st_t;

    typedef struct packed {
        logic                 vld;
        logic [BYTE_BITS-1:0] data;
    } bus_word_t;

    function automatic int unsigned slot_of(int unsigned cnt, logic rev, int unsigned words);
        return rev ? (words - 1 - cnt) : cnt;
    endfunction

endpackage

// File: rtl/seg_nibble_packer.sv
module seg_nibble_packer
    import seg_ldr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 take,
    input  logic                 wide,
    input  logic [BYTE_BITS-1:0] din,
    output bus_word_t            word_o
);

    logic [HALF_BITS-1:0] hi_q;
    logic                 hi_vld_q;

    always_comb begin
        if (wide) begin
            word_o.vld  = take;
            word_o.data = din;
        end else begin
            word_o.vld  = take && hi_vld_q;
            word_o.data = {hi_q, din[HALF_BITS-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hi_q     <= '0;
            hi_vld_q <= 1'b0;
        end else if (take && !wide) begin
            if (!hi_vld_q) begin
                hi_q     <= din[HALF_BITS-1:0];
                hi_vld_q <= 1'b1;
            end else begin
                hi_vld_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/seg_fill_ctrl.sv
module seg_fill_ctrl
    import seg_ldr_pkg::*;
#(
    parameter int unsigned WORDS = 20,
    localparam int unsigned CW   = $clog2(WORDS + 1),
    localparam int unsigned SW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lp,
    input  logic          en_in,
    input  logic          rev,
    input  logic          word_vld,
    output logic          take,
    output logic [SW-1:0] slot,
    output logic [CW-1:0] cnt,
    output logic          hand
);

    fill_st_t      state_q;
    logic [CW-1:0] cnt_q;
    logic          hand_q;
    logic          last_word;

    assign last_word = (cnt_q == CW'(WORDS - 1));
    assign take      = !lp && ((state_q == ST_FILL) || (state_q == ST_WAIT && en_in));
    assign slot      = SW'(slot_of(32'(cnt_q), rev, WORDS));
    assign cnt       = cnt_q;
    assign hand      = hand_q;

    always_ff @(posedge clk) begin
        if (rst || lp) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
            hand_q  <= 1'b0;
        end else begin
            hand_q <= (state_q == ST_HAND);
            case (state_q)
                ST_WAIT, ST_FILL: begin
                    if (take) begin
                        state_q <= ST_FILL;
                        if (word_vld) begin
                            cnt_q <= cnt_q + 1'b1;
                            if (last_word) state_q <= ST_HAND;
                        end
                    end
                end
                ST_HAND:  state_q <= ST_SPENT;
                default:  state_q <= ST_SPENT;
            endcase
        end
    end

endmodule

// File: rtl/seg_line_store.sv
module seg_line_store
    import seg_ldr_pkg::*;
#(
    parameter int unsigned WORDS = 20,
    localparam int unsigned SW   = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int unsigned PIX  = WORDS * BYTE_BITS
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           lp,
    input  bus_word_t      word,
    input  logic [SW-1:0]  slot,
    output logic [PIX-1:0] line_q
);

    logic [PIX-1:0] latch_flat;
    logic           lp_d;

    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        logic [BYTE_BITS-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= '0;
            end else if (word.vld && slot == SW'(g)) begin
                cell_q <= word.data;
            end
        end
        assign latch_flat[g*BYTE_BITS +: BYTE_BITS] = cell_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lp_d   <= 1'b0;
            line_q <= '0;
        end else begin
            lp_d <= lp;
            if (lp_d && !lp) line_q <= latch_flat;
        end
    end

endmodule

// File: rtl/seg_line_loader.sv
module seg_line_loader
    import seg_ldr_pkg::*;
#(
    parameter int unsigned PIXELS = 160
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lp,
    input  logic              wide_mode,
    input  logic              fill_rev,
    input  logic [7:0]        data_in,
    input  logic              chain_a_in,
    input  logic              chain_b_in,
    output logic              chain_a_out,
    output logic              chain_b_out,
    output logic [PIXELS-1:0] line_q
);

    localparam int unsigned WORDS = PIXELS / BYTE_BITS;
    localparam int unsigned CW    = $clog2(WORDS + 1);
    localparam int unsigned SW    = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic          en_in;
    logic          take;
    logic          hand;
    logic [SW-1:0] slot;
    logic [CW-1:0] word_cnt;
    bus_word_t     word;

    assign en_in       = fill_rev ? chain_b_in : chain_a_in;
    assign chain_a_out = fill_rev ? hand : 1'b0;
    assign chain_b_out = fill_rev ? 1'b0 : hand;

    seg_fill_ctrl #(.WORDS(WORDS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .lp       (lp),
        .en_in    (en_in),
        .rev      (fill_rev),
        .word_vld (word.vld),
        .take     (take),
        .slot     (slot),
        .cnt      (word_cnt),
        .hand     (hand)
    );

    seg_nibble_packer u_pack (
        .clk    (clk),
        .rst    (rst),
        .clr    (lp),
        .take   (take),
        .wide   (wide_mode),
        .din    (data_in),
        .word_o (word)
    );

    seg_line_store #(.WORDS(WORDS)) u_store (
        .clk    (clk),
        .rst    (rst),
        .lp     (lp),
        .word   (word),
        .slot   (slot),
        .line_q (line_q)
    );

endmodule

// File: rtl/seg_line_loader_chk.sv
module seg_line_loader_chk #(
    parameter int unsigned PIX = 160,
    localparam int unsigned WORDS = PIX / 8,
    localparam int unsigned CW    = $clog2(WORDS + 1)
) (
    input logic           clk,
    input logic           rst,
    input logic           lp,
    input logic           take,
    input logic           word_vld,
    input logic [CW-1:0]  cnt,
    input logic           chain_a_out,
    input logic           chain_b_out,
    input logic [PIX-1:0] line_q
);

    logic lp_q;
    always_ff @(posedge clk) begin
        if (rst) lp_q <= 1'b0;
        else     lp_q <= lp;
    end

    p_lp_blocks_capture_r7: assert property (@(posedge clk) disable iff (rst)
        lp |-> !take);

    p_cnt_limit_r6: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(WORDS));

    p_full_no_write_r6: assert property (@(posedge clk) disable iff (rst)
        (cnt == CW'(WORDS)) |-> !word_vld);

    p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
        (chain_a_out || chain_b_out) |=> !(chain_a_out || chain_b_out));

    p_pulse_after_full_r5: assert property (@(posedge clk) disable iff (rst)
        (chain_a_out || chain_b_out) |-> (cnt == CW'(WORDS)));

    p_line_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(lp_q && !lp) |=> $stable(line_q));

    p_one_output_r9: assert property (@(posedge clk) disable iff (rst)
        !(chain_a_out && chain_b_out));

endmodule

bind seg_line_loader seg_line_loader_chk #(.PIX(PIXELS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .lp          (lp),
    .take        (take),
    .word_vld    (word.vld),
    .cnt         (word_cnt),
    .chain_a_out (chain_a_out),
    .chain_b_out (chain_b_out),
    .line_q      (line_q)
);

// File: tb/test_seg_line_loader.sv
module test_seg_line_loader;

    localparam int CLK_PERIOD = 10;
    localparam int PIX        = 160;
    localparam int WORDS      = PIX / 8;

    logic           clk = 1'b0;
    logic           rst, lp, wide_mode, fill_rev, chain_a_in, chain_b_in;
    logic [7:0]     data_in;
    logic           chain_a_out, chain_b_out;
    logic [PIX-1:0] line_q;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_line_loader #(.PIXELS(PIX)) i_seg_line_loader (
        .clk(clk), .rst(rst), .lp(lp), .wide_mode(wide_mode), .fill_rev(fill_rev),
        .data_in(data_in), .chain_a_in(chain_a_in), .chain_b_in(chain_b_in),
        .chain_a_out(chain_a_out), .chain_b_out(chain_b_out), .line_q(line_q)
    );

    task automatic chk(bit ok, string req, logic [PIX-1:0] act, logic [PIX-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(int w, int seed);
        return 8'((w * 29 + seed * 71) ^ 8'hA5);
    endfunction

    function automatic logic [PIX-1:0] expect_line(bit rev, int seed);
        logic [PIX-1:0] e = '0;
        for (int w = 0; w < WORDS; w++) begin
            int pos = rev ? (WORDS - 1 - w) : w;
            e[pos*8 +: 8] = pat(w, seed);
        end
        return e;
    endfunction

    task automatic set_en(bit rev, bit v);
        if (rev) chain_b_in = v; else chain_a_in = v;
    endtask

    task automatic idle_noise(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chain_a_in = 1'b0; chain_b_in = 1'b0;
            data_in = 8'(8'hFF - i);
        end
    endtask

    task automatic latch_pulse();
        @(negedge clk); chain_a_in = 1'b0; chain_b_in = 1'b0; lp = 1'b1;
        @(negedge clk); lp = 1'b0;
        @(negedge clk);
    endtask

    // Drive words of a line; the enable is raised only with the first transfer.
    task automatic feed_words(bit wide, bit rev, int seed, int nwords, bit extra_nibble);
        wide_mode = wide; fill_rev = rev;
        for (int w = 0; w < nwords; w++) begin
            logic [7:0] b = pat(w, seed);
            if (wide) begin
                @(negedge clk); data_in = b; set_en(rev, w == 0);
            end else begin
                @(negedge clk); data_in = {4'hC, b[7:4]}; set_en(rev, w == 0);
                @(negedge clk); data_in = {4'h3, b[3:0]}; set_en(rev, 1'b0);
            end
        end
        if (extra_nibble) begin
            @(negedge clk); data_in = 8'h0F; set_en(rev, 1'b0);
        end
    endtask

    // Handoff timing plus the absence of capture and pulses after completion.
    task automatic check_handoff(bit rev, string req);
        logic out_pin, other_pin;
        int   extra = 0;
        @(negedge clk); set_en(rev, 1'b1); data_in = 8'h00;
        out_pin = rev ? chain_a_out : chain_b_out;
        chk(out_pin == 1'b0, {req, " R5 no pulse on capture edge"}, PIX'(out_pin), '0);
        @(negedge clk); data_in = 8'h11;
        out_pin   = rev ? chain_a_out : chain_b_out;
        other_pin = rev ? chain_b_out : chain_a_out;
        chk(out_pin == 1'b1, {req, " R5 pulse after final word"}, PIX'(out_pin), PIX'(1));
        chk(other_pin == 1'b0, {req, " R9 unused chain output low"}, PIX'(other_pin), '0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); data_in = 8'(8'h22 * i);
            if (chain_a_out || chain_b_out) extra++;
        end
        chk(extra == 0, {req, " R5 R6 single pulse only"}, PIX'(extra), '0);
        set_en(rev, 1'b0);
    endtask

    task automatic t_reset();
        chk(line_q == '0, "R1 line after reset", line_q, '0);
        chk(!chain_a_out && !chain_b_out, "R1 chain outputs after reset",
            PIX'({chain_a_out, chain_b_out}), '0);
    endtask

    task automatic t_byte_left();
        logic [PIX-1:0] e = expect_line(1'b0, 1);
        wide_mode = 1'b1; fill_rev = 1'b0;
        idle_noise(5);
        feed_words(1'b1, 1'b0, 1, WORDS, 1'b0);
        check_handoff(1'b0, "byte-left");
        idle_noise(3);
        chk(line_q == '0, "R8 line unchanged before latch fall", line_q, '0);
        latch_pulse();
        chk(line_q == e, "R2 R4 R6 byte line left fill", line_q, e);
        idle_noise(10);
        chk(line_q == e, "R8 line holds without latch pulse", line_q, e);
        latch_pulse();
        chk(line_q == e, "R4 idle clocks ignored, relatch same", line_q, e);
    endtask

    task automatic t_nibble_left();
        logic [PIX-1:0] e = expect_line(1'b0, 2);
        feed_words(1'b0, 1'b0, 2, WORDS, 1'b0);
        check_handoff(1'b0, "nibble-left");
        latch_pulse();
        chk(line_q == e, "R3 nibble line assembly", line_q, e);
    endtask

    task automatic t_byte_right();
        logic [PIX-1:0] e = expect_line(1'b1, 3);
        wide_mode = 1'b1; fill_rev = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); chain_a_in = 1'b1; data_in = 8'hFF;
        end
        @(negedge clk); chain_a_in = 1'b0;
        feed_words(1'b1, 1'b1, 3, WORDS, 1'b0);
        check_handoff(1'b1, "byte-right");
        latch_pulse();
        chk(line_q == e, "R9 reverse fill and b-side enable", line_q, e);
    endtask

    task automatic t_abort();
        logic [PIX-1:0] e = expect_line(1'b0, 5);
        feed_words(1'b0, 1'b0, 4, 7, 1'b1);
        latch_pulse();
        feed_words(1'b0, 1'b0, 5, WORDS, 1'b0);
        check_handoff(1'b0, "abort-restart");
        latch_pulse();
        chk(line_q == e, "R7 restart after mid-line latch pulse", line_q, e);
    endtask

    initial begin
        rst = 1'b1; lp = 1'b0; wide_mode = 1'b1; fill_rev = 1'b0;
        chain_a_in = 1'b0; chain_b_in = 1'b0; data_in = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_byte_left();
        t_nibble_left();
        t_byte_right();
        t_abort();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule